// File: doc/BRIEF.md
# Token Circuit Switch

A crosspoint switch that joins a set of input token links to a set of output token links. Every token on a link is a data word plus a one-bit flag that separates control tokens from data tokens. A message starts with a single header data token that names an output. The switch consumes the header and claims that output for the input. Every later token from that input, data or control, then goes to the claimed output. The route closes only when an end-of-message control token has passed through. A route can therefore serve as a long-lived streamed circuit, or be opened and closed once per packet to give dynamic packet routing.

Each output has its own round-robin arbiter. When several inputs ask for the same free output, one of them wins. The others see their ready signal held low until the output is released and their turn comes. A header that names an output index beyond the last port opens no route. That message is read and thrown away, up to and including its end-of-message token. All links use a valid/ready handshake. A token moves on the edge where valid and ready are both high.

Top module: `tcs_switch`

## Requirements
- R1: A token is a DATA_W-bit word plus a control flag (1 = control, 0 = data). A control token whose word equals EOM_CODE (default 0) marks the end of a message; any other control token is ordinary traffic.
- R2: At an idle input, the first data token is a header. It is always accepted (ready high) and is never forwarded. Its low DEST_W bits give the output index and its upper bits are ignored. If that output is free, the first payload token appears on it in the second cycle after the header handshake.
- R3: While a route is open, every token from the input, data or non-final control, is presented on the routed output in the same cycle and in order. The input's ready equals that output's ready.
- R4: The end-of-message token is forwarded on the open route. On its handshake edge the route closes: the output becomes free and the input returns to idle.
- R5: Each output grants waiting inputs in round-robin order, starting one index past the last input it granted (index 0 after reset). A waiting input holds ready low. After a release, the next grant takes effect one edge after the output is free, so a waiter's first token shows two cycles after the end-of-message handshake.
- R6: A header whose index is N_OUT or above opens no route. The input keeps ready high and discards every token up to and including the next end-of-message token, and no output shows valid. A following header is then handled normally.
- R7: After reset no route is held: every out_valid is low and every in_ready is high.
- R8: A control token that reaches an idle input, end-of-message or not, is accepted and discarded without opening a route.
- R9: Any input can reach any output, routes to different outputs carry traffic in the same cycle, and one input holds at most one output at a time.
- R10: An output that shows valid while its ready is low keeps the same token until it is taken, given that the input holds its token under backpressure.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | N_IN | Token present on each input link |
| in_ctrl | input | N_IN | Control flag for each input token |
| in_data | input | N_IN x DATA_W | Token word for each input link |
| in_ready | output | N_IN | Switch accepts the token on each input link |
| out_valid | output | N_OUT | Token present on each output link |
| out_ctrl | output | N_OUT | Control flag for each output token |
| out_data | output | N_OUT x DATA_W | Token word for each output link |
| out_ready | input | N_OUT | Downstream accepts the token on each output link |

## Verification
Forwarding on an open route is combinational, so a token and its ready show up at the ports in the cycle the token is driven. The header takes effect two edges later: one edge to record the request and one to grant it. A waiting input's first token is due two cycles after the end-of-message handshake that freed the output. The bench drives inputs on the falling edge and samples every port one time unit before the next rising edge. The directed checks are written cycle by cycle against these latencies. The random phase compares each delivered token with a per-input queue of expected tokens, so it does not depend on which input the arbiters choose.

// File: rtl/tcs_pkg.sv
package tcs_pkg;

   // Per-input routing state
   typedef enum logic [1:0] {
      PS_IDLE = 2'd0,   // waiting for a header
      PS_WAIT = 2'd1,   // header taken, requesting an output
      PS_OPEN = 2'd2,   // route held, tokens flow through
      PS_DROP = 2'd3    // bad header, discarding to end of message
   } port_st_e;

endpackage

// File: rtl/tcs_rr_arb.sv
module tcs_rr_arb #(
   parameter int N = 4
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         en,
   input  logic [N-1:0] req,
   output logic [N-1:0] gnt
);

   if (N < 1) begin : g_bad_n
      $error("tcs_rr_arb: N must be at least 1");
   end

   if (N == 1) begin : g_single
      assign gnt = en ? req : '0;
   end else begin : g_rr
      localparam int PW = $clog2(N);

      logic [PW-1:0] ptr_q;
      logic [PW-1:0] ptr_d;
      logic          found;
      int            idx;

      always_comb begin
         gnt   = '0;
         ptr_d = ptr_q;
         found = 1'b0;
         idx   = 0;
         if (en) begin
            for (int k = 0; k < N; k++) begin
               idx = int'(ptr_q) + k;
               if (idx >= N) idx = idx - N;
               if (!found && req[idx]) begin
                  found    = 1'b1;
                  gnt[idx] = 1'b1;
                  ptr_d    = (idx == N - 1) ? '0 : PW'(idx + 1);
               end
            end
         end
      end

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) ptr_q <= '0;
         else        ptr_q <= ptr_d;
      end
   end

endmodule

// File: rtl/tcs_in_port.sv
module tcs_in_port
   import tcs_pkg::*;
#(
   parameter int DATA_W   = 8,
   parameter int DEST_W   = 2,
   parameter int N_OUT    = 3,
   parameter int unsigned EOM_CODE = 0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tok_valid,
   input  logic              tok_ctrl,
   input  logic [DATA_W-1:0] tok_data,
   output logic              tok_ready,
   input  logic              granted,
   input  logic              fwd_ready,
   output port_st_e          state,
   output logic [DEST_W-1:0] dest
);

   localparam logic [DATA_W-1:0] EOM_W = DATA_W'(EOM_CODE);

   port_st_e          st_q;
   logic [DEST_W-1:0] dest_q;
   logic              is_eom;
   logic              hdr_ok;

   assign is_eom = tok_ctrl && (tok_data == EOM_W);
   assign hdr_ok = int'(tok_data[DEST_W-1:0]) < N_OUT;

   always_comb begin
      case (st_q)
         PS_WAIT: tok_ready = 1'b0;
         PS_OPEN: tok_ready = fwd_ready;
         default: tok_ready = 1'b1;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q   <= PS_IDLE;
         dest_q <= '0;
      end else begin
         case (st_q)
            PS_IDLE: begin
               if (tok_valid && !tok_ctrl) begin
                  dest_q <= tok_data[DEST_W-1:0];
                  st_q   <= hdr_ok ? PS_WAIT : PS_DROP;
               end
            end
            PS_WAIT: begin
               if (granted) st_q <= PS_OPEN;
            end
            PS_OPEN: begin
               if (tok_valid && fwd_ready && is_eom) st_q <= PS_IDLE;
            end
            default: begin
               if (tok_valid && is_eom) st_q <= PS_IDLE;
            end
         endcase
      end
   end

   assign state = st_q;
   assign dest  = dest_q;

endmodule

// File: rtl/tcs_switch.sv
module tcs_switch
   import tcs_pkg::*;
#(
   parameter int N_IN   = 4,
   parameter int N_OUT  = 3,
   parameter int DATA_W = 8,
   parameter int DEST_W = 2,
   parameter int unsigned EOM_CODE = 0
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic [N_IN-1:0]               in_valid,
   input  logic [N_IN-1:0]               in_ctrl,
   input  logic [N_IN-1:0][DATA_W-1:0]   in_data,
   output logic [N_IN-1:0]               in_ready,
   output logic [N_OUT-1:0]              out_valid,
   output logic [N_OUT-1:0]              out_ctrl,
   output logic [N_OUT-1:0][DATA_W-1:0]  out_data,
   input  logic [N_OUT-1:0]              out_ready
);

   localparam int IW = (N_IN > 1) ? $clog2(N_IN) : 1;
   localparam logic [DATA_W-1:0] EOM_W = DATA_W'(EOM_CODE);

   if (N_IN < 1 || N_OUT < 1) begin : g_bad_count
      $error("tcs_switch: N_IN and N_OUT must be at least 1");
   end
   if (DEST_W < 1 || DEST_W > DATA_W || DEST_W < $clog2(N_OUT)) begin : g_bad_dest
      $error("tcs_switch: DEST_W must cover N_OUT and fit in DATA_W");
   end
   if (DATA_W < 32 && EOM_CODE >= (32'd1 << DATA_W)) begin : g_bad_eom
      $error("tcs_switch: EOM_CODE does not fit in DATA_W");
   end

   port_st_e                        st [N_IN];
   logic [N_IN-1:0][DEST_W-1:0]     dest;
   logic [N_OUT-1:0][N_IN-1:0]      req;
   logic [N_OUT-1:0][N_IN-1:0]      arb_gnt;
   logic [N_OUT-1:0]                busy_q;
   logic [N_OUT-1:0][IW-1:0]        owner_q;
   logic [N_OUT-1:0]                rel;

   // Input side: one routing state machine per link
   for (genvar i = 0; i < N_IN; i++) begin : g_in
      logic fr;
      logic gr;

      always_comb begin
         fr = 1'b0;
         for (int o = 0; o < N_OUT; o++)
            if (dest[i] == DEST_W'(o)) fr = out_ready[o];
      end

      always_comb begin
         gr = 1'b0;
         for (int o = 0; o < N_OUT; o++) gr = gr | arb_gnt[o][i];
      end

      tcs_in_port #(
         .DATA_W   (DATA_W),
         .DEST_W   (DEST_W),
         .N_OUT    (N_OUT),
         .EOM_CODE (EOM_CODE)
      ) u_port (
         .clk       (clk),
         .rst_n     (rst_n),
         .tok_valid (in_valid[i]),
         .tok_ctrl  (in_ctrl[i]),
         .tok_data  (in_data[i]),
         .tok_ready (in_ready[i]),
         .granted   (gr),
         .fwd_ready (fr),
         .state     (st[i]),
         .dest      (dest[i])
      );
   end

   // Output side: arbiter, owner register and crosspoint column per link
   for (genvar o = 0; o < N_OUT; o++) begin : g_out
      logic          busy_r;
      logic [IW-1:0] own_r;
      logic [IW-1:0] own_d;

      for (genvar i = 0; i < N_IN; i++) begin : g_req
         assign req[o][i] = (st[i] == PS_WAIT) && (dest[i] == DEST_W'(o));
      end

      tcs_rr_arb #(.N(N_IN)) u_arb (
         .clk   (clk),
         .rst_n (rst_n),
         .en    (!busy_r),
         .req   (req[o]),
         .gnt   (arb_gnt[o])
      );

      always_comb begin
         own_d = '0;
         for (int i = 0; i < N_IN; i++)
            if (arb_gnt[o][i]) own_d = IW'(i);
      end

      assign out_valid[o] = busy_r && in_valid[own_r];
      assign out_ctrl[o]  = in_ctrl[own_r];
      assign out_data[o]  = in_data[own_r];
      assign rel[o]       = out_valid[o] && out_ready[o] && out_ctrl[o]
                            && (out_data[o] == EOM_W);

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            busy_r <= 1'b0;
            own_r  <= '0;
         end else if (!busy_r) begin
            if (|arb_gnt[o]) begin
               busy_r <= 1'b1;
               own_r  <= own_d;
            end
         end else if (rel[o]) begin
            busy_r <= 1'b0;
         end
      end

      assign busy_q[o]  = busy_r;
      assign owner_q[o] = own_r;
   end

endmodule

// File: rtl/tcs_switch_chk.sv
module tcs_switch_chk #(
   parameter int N_IN   = 4,
   parameter int N_OUT  = 3,
   parameter int DATA_W = 8,
   parameter int IW     = 2
) (
   input logic                          clk,
   input logic                          rst_n,
   input logic [N_OUT-1:0]              out_valid,
   input logic [N_OUT-1:0]              out_ready,
   input logic [N_OUT-1:0]              out_ctrl,
   input logic [N_OUT-1:0][DATA_W-1:0]  out_data,
   input logic [N_OUT-1:0]              busy,
   input logic [N_OUT-1:0][IW-1:0]      owner,
   input logic [N_OUT-1:0][N_IN-1:0]    arb_gnt,
   input logic [N_OUT-1:0]              rel
);

   for (genvar o = 0; o < N_OUT; o++) begin : g_o
      // R5
      gnt_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
         $onehot0(arb_gnt[o]));

      // R3
      route_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (busy[o] && !rel[o]) |=> (busy[o] && $stable(owner[o])));

      // R4
      route_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
         rel[o] |=> !busy[o]);

      // R10
      out_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (out_valid[o] && !out_ready[o]) |=>
            (out_valid[o] && $stable(out_data[o]) && $stable(out_ctrl[o])));
   end

   for (genvar i = 0; i < N_IN; i++) begin : g_i
      logic [N_OUT-1:0] owns;
      always_comb begin
         for (int o = 0; o < N_OUT; o++)
            owns[o] = busy[o] && (owner[o] == IW'(i));
      end

      // R9
      single_route_chk: assert property (@(posedge clk) disable iff (!rst_n)
         $onehot0(owns));
   end

endmodule

bind tcs_switch tcs_switch_chk #(
   .N_IN   (N_IN),
   .N_OUT  (N_OUT),
   .DATA_W (DATA_W),
   .IW     (IW)
) i_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .out_valid (out_valid),
   .out_ready (out_ready),
   .out_ctrl  (out_ctrl),
   .out_data  (out_data),
   .busy      (busy_q),
   .owner     (owner_q),
   .arb_gnt   (arb_gnt),
   .rel       (rel)
);

// File: tb/test_tcs_switch.sv
module test_tcs_switch;

   localparam int CLK_P = 10;
   localparam int SMP   = CLK_P / 2 - 1;
   localparam int NI    = 4;
   localparam int NO    = 3;
   localparam int NMSG  = 40;
   localparam int WD    = 100000;

   logic                 clk = 1'b0;
   logic                 rst_n = 1'b0;
   logic [NI-1:0]        in_valid = '0;
   logic [NI-1:0]        in_ctrl = '0;
   logic [NI-1:0][7:0]   in_data = '0;
   logic [NI-1:0]        in_ready;
   logic [NO-1:0]        out_valid;
   logic [NO-1:0]        out_ctrl;
   logic [NO-1:0][7:0]   out_data;
   logic [NO-1:0]        out_ready = '1;

   int n_chk  = 0;
   int n_fail = 0;
   bit mon_en = 1'b0;
   bit rnd_on = 1'b0;
   int cur_src [NO];
   logic [10:0] exp_q [NI][$];   // {dest[1:0], ctrl, data[7:0]}

   always #(CLK_P / 2) clk = ~clk;

   tcs_switch i_tcs_switch (
      .clk       (clk),
      .rst_n     (rst_n),
      .in_valid  (in_valid),
      .in_ctrl   (in_ctrl),
      .in_data   (in_data),
      .in_ready  (in_ready),
      .out_valid (out_valid),
      .out_ctrl  (out_ctrl),
      .out_data  (out_data),
      .out_ready (out_ready)
   );

   task automatic chk(bit ok, string tag, int act, int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
      end
   endtask

   function automatic logic [7:0] tok(int src, int seq);
      return {2'(src), 6'(seq)};
   endfunction

   task automatic drv(int i, logic v, logic c, logic [7:0] d);
      in_valid[i] = v;
      in_ctrl[i]  = c;
      in_data[i]  = d;
   endtask

   // Hold a token until the switch takes it
   task automatic send(int i, logic c, logic [7:0] d);
      @(negedge clk);
      drv(i, 1'b1, c, d);
      forever begin
         #(SMP);
         if (in_ready[i]) begin
            @(posedge clk);
            break;
         end
         @(negedge clk);
      end
   endtask

   task automatic run_input(int i);
      int seq = 1;
      for (int m = 0; m < NMSG; m++) begin
         int d   = $urandom_range(0, 3);
         int len = $urandom_range(1, 5);
         send(i, 1'b0, {6'($urandom), 2'(d)});
         for (int t = 0; t < len; t++) begin
            logic       c  = ($urandom % 5) == 0;
            logic [7:0] dt = tok(i, seq);
            seq = (seq == 63) ? 1 : seq + 1;
            if (d < NO) exp_q[i].push_back({2'(d), c, dt});
            send(i, c, dt);
         end
         if (d < NO) exp_q[i].push_back({2'(d), 1'b1, 8'h00});
         send(i, 1'b1, 8'h00);
         for (int g = $urandom_range(0, 2); g > 0; g--) begin
            @(negedge clk);
            in_valid[i] = 1'b0;
         end
      end
      @(negedge clk);
      in_valid[i] = 1'b0;
   endtask

   // Random downstream backpressure
   initial begin
      forever begin
         @(negedge clk);
         if (rnd_on)
            for (int o = 0; o < NO; o++) out_ready[o] = ($urandom % 4) != 0;
      end
   end

   // Scoreboard on the output links
   initial begin
      int          s;
      logic [10:0] e;
      logic [10:0] got;
      for (int o = 0; o < NO; o++) cur_src[o] = -1;
      forever begin
         @(negedge clk);
         #(SMP);
         if (mon_en) begin
            for (int o = 0; o < NO; o++) begin
               if (out_valid[o] && out_ready[o]) begin
                  got = {2'(o), out_ctrl[o], out_data[o]};
                  s   = (cur_src[o] < 0) ? int'(out_data[o][7:6]) : cur_src[o];
                  if (exp_q[s].size() == 0) begin
                     chk(1'b0, "R9 token with no pending message", int'(got), 0);
                  end else begin
                     e = exp_q[s].pop_front();
                     chk(got == e, "R3 R9 delivered token", int'(got), int'(e));
                  end
                  cur_src[o] = (out_ctrl[o] && out_data[o] == 8'h00) ? -1 : s;
               end
            end
         end
      end
   end

   initial begin
      repeat (WD) @(posedge clk);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d cycles", WD, WD - 1);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      void'($urandom(32'h5EED_0042));
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;

      // R7: idle after reset
      #(SMP);
      chk(out_valid == '0, "R7 out_valid after reset", int'(out_valid), 0);
      chk(in_ready == '1, "R7 in_ready after reset", int'(in_ready), 'hF);

      // R2 R3 R4 R10: input 0 to output 2
      @(negedge clk); drv(0, 1, 0, 8'h02); #(SMP);
      chk(in_ready[0], "R2 header accepted at idle", int'(in_ready[0]), 1);
      @(negedge clk); drv(0, 1, 0, tok(0, 1)); #(SMP);
      chk(!in_ready[0], "R2 waiting for grant", int'(in_ready[0]), 0);
      chk(out_valid == '0, "R2 header not forwarded", int'(out_valid), 0);
      @(negedge clk); #(SMP);
      chk(out_valid == 3'b100, "R2 route open two cycles on", int'(out_valid), 4);
      chk(out_data[2] == tok(0, 1) && !out_ctrl[2], "R3 payload data", int'(out_data[2]), int'(tok(0, 1)));
      @(negedge clk); drv(0, 1, 1, 8'h05); #(SMP);
      chk(out_valid[2] && out_ctrl[2] && out_data[2] == 8'h05, "R1 R3 plain control forwarded",
          int'({out_ctrl[2], out_data[2]}), 'h105);
      @(negedge clk); drv(0, 1, 0, tok(0, 2)); out_ready[2] = 1'b0; #(SMP);
      chk(out_valid[2] && !in_ready[0], "R3 ready follows output ready", int'(in_ready[0]), 0);
      @(negedge clk); #(SMP);
      chk(out_valid[2] && out_data[2] == tok(0, 2), "R10 token held under stall", int'(out_data[2]), int'(tok(0, 2)));
      @(negedge clk); out_ready[2] = 1'b1; #(SMP);
      chk(in_ready[0], "R3 ready returns", int'(in_ready[0]), 1);
      @(negedge clk); drv(0, 1, 1, 8'h00); #(SMP);
      chk(out_valid[2] && out_ctrl[2] && out_data[2] == 8'h00, "R4 end token forwarded",
          int'({out_valid[2], out_ctrl[2], out_data[2]}), 'h300);
      @(negedge clk); drv(0, 0, 0, 8'h00); #(SMP);
      chk(out_valid == '0 && in_ready[0], "R4 route closed", int'({out_valid, in_ready[0]}), 1);

      // R8 and upper header bits: input 1
      @(negedge clk); drv(1, 1, 1, 8'h07); #(SMP);
      chk(in_ready[1] && out_valid == '0, "R8 control at idle discarded", int'({in_ready[1], out_valid}), 8);
      @(negedge clk); drv(1, 1, 1, 8'h00); #(SMP);
      chk(in_ready[1] && out_valid == '0, "R8 end token at idle discarded", int'({in_ready[1], out_valid}), 8);
      @(negedge clk); drv(1, 1, 0, 8'h7C); #(SMP);
      @(negedge clk); drv(1, 1, 0, tok(1, 1)); #(SMP);
      chk(!in_ready[1], "R8 next data token is the header", int'(in_ready[1]), 0);
      @(negedge clk); #(SMP);
      chk(out_valid == 3'b001 && out_data[0] == tok(1, 1), "R2 low header bits pick output 0",
          int'({out_valid, out_data[0]}), int'({3'b001, tok(1, 1)}));
      @(negedge clk); drv(1, 1, 1, 8'h00); #(SMP);
      @(negedge clk); drv(1, 0, 0, 8'h00); #(SMP);

      // R6: bad output index on input 2
      @(negedge clk); drv(2, 1, 0, 8'h03); #(SMP);
      @(negedge clk); drv(2, 1, 0, 8'hAA); #(SMP);
      chk(in_ready[2] && out_valid == '0, "R6 payload dropped", int'({in_ready[2], out_valid}), 8);
      @(negedge clk); drv(2, 1, 1, 8'h09); #(SMP);
      chk(in_ready[2] && out_valid == '0, "R6 control dropped", int'({in_ready[2], out_valid}), 8);
      @(negedge clk); drv(2, 1, 1, 8'h00); #(SMP);
      chk(in_ready[2] && out_valid == '0, "R6 end token dropped", int'({in_ready[2], out_valid}), 8);
      @(negedge clk); drv(2, 1, 0, 8'h00); #(SMP);
      @(negedge clk); drv(2, 1, 0, tok(2, 1)); #(SMP);
      chk(!in_ready[2], "R6 later header opens route", int'(in_ready[2]), 0);
      @(negedge clk); #(SMP);
      chk(out_valid == 3'b001 && out_data[0] == tok(2, 1), "R6 later message delivered",
          int'(out_data[0]), int'(tok(2, 1)));
      @(negedge clk); drv(2, 1, 1, 8'h00); #(SMP);

      // R5: input 2 uses output 1 first, so the pointer moves past it
      send(2, 0, 8'h01);
      send(2, 0, tok(2, 2));
      send(2, 1, 8'h00);
      @(negedge clk); drv(2, 0, 0, 0); drv(0, 1, 0, 8'h01); drv(3, 1, 0, 8'h01); #(SMP);
      @(negedge clk); drv(0, 1, 0, tok(0, 3)); drv(3, 1, 0, tok(3, 1)); #(SMP);
      chk(in_ready[0] == 1'b0 && in_ready[3] == 1'b0 && !out_valid[1], "R5 both waiting",
          int'({in_ready[3], in_ready[0], out_valid[1]}), 0);
      @(negedge clk); #(SMP);
      chk(out_valid[1] && out_data[1] == tok(3, 1), "R5 round robin picks input 3",
          int'(out_data[1]), int'(tok(3, 1)));
      chk(!in_ready[0], "R5 loser held off", int'(in_ready[0]), 0);
      @(negedge clk); drv(3, 1, 1, 8'h00); #(SMP);
      chk(!in_ready[0], "R5 loser held during end token", int'(in_ready[0]), 0);
      @(negedge clk); drv(3, 0, 0, 0); #(SMP);
      chk(!out_valid[1] && !in_ready[0], "R5 output free, grant pending", int'({out_valid[1], in_ready[0]}), 0);
      @(negedge clk); #(SMP);
      chk(out_valid[1] && out_data[1] == tok(0, 3) && in_ready[0], "R5 waiter granted",
          int'(out_data[1]), int'(tok(0, 3)));
      @(negedge clk); drv(0, 1, 1, 8'h00); #(SMP);
      @(negedge clk); drv(0, 0, 0, 0); #(SMP);
      chk(out_valid == '0, "R4 all routes closed", int'(out_valid), 0);

      // R3 R9: random traffic on all links
      mon_en = 1'b1;
      rnd_on = 1'b1;
      fork
         run_input(0);
         run_input(1);
         run_input(2);
         run_input(3);
      join
      @(negedge clk);
      rnd_on = 1'b0;
      out_ready = '1;
      repeat (20) @(negedge clk);
      for (int i = 0; i < NI; i++)
         chk(exp_q[i].size() == 0, "R9 all messages delivered", exp_q[i].size(), 0);
      for (int o = 0; o < NO; o++)
         chk(cur_src[o] == -1, "R4 every route closed at end", cur_src[o], -1);

      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

endmodule